// File: doc/BRIEF.md
# Two-Wire Slave Register Window

This block is a serial two-wire bus slave that exposes a 128-byte register and memory space to an external bus master. The two bus lines are oversampled by a faster system clock. Start and stop conditions and SCL edges are recognised on synchronised copies of the lines. The slave answers to a 7-bit device address. The top four bits of that address are a fixed type code. The lower three bits come from strap pins.

A write transfer carries a word-address byte that loads an internal pointer. Zero or more data bytes follow it. Each data byte is stored at the pointer, the pointer steps forward, and a one-cycle strobe with the address and data goes out to an external write-cycle controller. A read transfer streams bytes from the pointer for as long as the master acknowledges each one.

While the controller reports that a write cycle is busy, the slave stays off the bus entirely. SDA is driven as an open-drain output: the single output-enable pin pulls the line low and never drives it high.

Top module: `twi_regmem_slave`

## Requirements
- R1: A rising SDA while SCL is high is a stop. It returns the engine to idle and releases SDA, whatever phase the transfer is in.
- R2: The first byte after a start is matched against the type code 4'b1010 in bits 7..4 and `strap_i` in bits 3..1. On a match, SDA is pulled low for the whole ninth clock. Bit 0 selects the direction: 1 is read, 0 is write.
- R3: A first byte that does not match gets no acknowledge. The slave then neither drives SDA nor stores anything until the next start.
- R4: In a write transfer the slave acknowledges the word-address byte and every data byte. The low 7 bits of the word-address byte load the pointer, and its bit 7 is ignored.
- R5: Each written data byte is stored at the pointer and reported by a one-cycle `wr_stb_o` pulse carrying that pointer and the byte. The pointer then increments, and it wraps from 127 to 0.
- R6: In a read transfer the slave sends the byte at the pointer MSB first and releases SDA for the ninth clock. The pointer increments after each byte sent, wrapping from 127 to 0. A low SDA level in the ninth clock makes the slave send the next byte.
- R7: A high SDA level in the ninth clock of a read (NACK) ends the slave's driving. It stays silent until the next start.
- R8: A repeated start in any phase returns the engine to the address phase. A read that follows a write carrying only the word-address byte starts at the address just loaded.
- R9: While `wc_busy_i` is high the slave does not acknowledge, drive SDA or strobe any write, even for its own address.
- R10: `sda_oe_o` is asserted only in the first cycles after a sampled SCL falling edge, never while the sampled SCL is high.
- R11: After reset `sda_oe_o` and `wr_stb_o` are low and the engine is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (as seen on the wire) |
| strap_i | input | 3 | Device address strap bits, compared with address bits 3..1 |
| wc_busy_i | input | 1 | Write-cycle controller busy; silences the slave |
| sda_oe_o | output | 1 | Pull SDA low when high; release when low |
| wr_stb_o | output | 1 | One-cycle pulse per written data byte |
| wr_addr_o | output | 7 | Word address of the written byte |
| wr_data_o | output | 8 | Written byte |

## Verification
Suppose the bit counter or the phase flag slips by one position. The very next acknowledge slot then shows it: the ninth-clock sample reads high where a low was due, or the slave pulls low over a data bit. The error therefore surfaces within one byte time. A pointer fault shows up at the first byte read back, and in the address carried by the next write strobe. A slave that fails to go silent after a mismatch, a NACK or a busy indication is caught in the very clock it pulls the line low, because the output enable is checked on every clock during those windows.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_WADDR = 3'd2,
    ST_WDATA = 3'd3,
    ST_RDATA = 3'd4
  } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twi_regfile.sv
module twi_regfile #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/twi_proto_fsm.sv
module twi_proto_fsm
  import twi_pkg::*;
#(
  parameter int          AW        = 7,
  parameter int          DW        = 8,
  parameter int          SW        = 3,
  parameter logic [3:0]  TYPE_CODE = 4'b1010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic [SW-1:0] strap_i,
  input  logic          busy_i,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] ptr,
  output logic          sda_oe,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int          CW    = $clog2(DW + 1);
  localparam logic [CW-1:0] BITS = CW'(DW);

  twi_state_e    state;
  logic [CW-1:0] bitcnt;
  logic          ack_ph;
  logic          mack;
  logic [DW-1:0] shreg;
  logic [DW-1:0] txsh;
  logic          addr_hit;

  assign addr_hit = (shreg[DW-1 -: 4] == TYPE_CODE) && (shreg[SW:1] == strap_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      ack_ph  <= 1'b0;
      mack    <= 1'b1;
      shreg   <= '0;
      txsh    <= '0;
      sda_oe  <= 1'b0;
      ptr     <= '0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (busy_i || stop_evt) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
        ack_ph <= 1'b0;
      end else if (start_evt) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        ack_ph <= 1'b0;
        sda_oe <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (scl_rise) begin
          if (ack_ph) mack <= sda_s;
          else if (bitcnt != BITS) begin
            bitcnt <= bitcnt + 1'b1;
            shreg  <= {shreg[DW-2:0], sda_s};
          end
        end else if (scl_fall) begin
          if (ack_ph) begin
            // end of the ninth clock
            ack_ph <= 1'b0;
            bitcnt <= '0;
            sda_oe <= 1'b0;
            case (state)
              ST_ADDR: begin
                if (shreg[0]) begin
                  state  <= ST_RDATA;
                  txsh   <= rd_data;
                  sda_oe <= ~rd_data[DW-1];
                end else state <= ST_WADDR;
              end
              ST_WADDR: state <= ST_WDATA;
              ST_RDATA: begin
                if (mack) state <= ST_IDLE;
                else begin
                  txsh   <= rd_data;
                  sda_oe <= ~rd_data[DW-1];
                end
              end
              default: state <= state;
            endcase
          end else if (bitcnt == BITS) begin
            // start of the ninth clock
            ack_ph <= 1'b1;
            case (state)
              ST_ADDR: begin
                if (addr_hit) sda_oe <= 1'b1;
                else begin
                  state  <= ST_IDLE;
                  ack_ph <= 1'b0;
                end
              end
              ST_WADDR: begin
                ptr    <= shreg[AW-1:0];
                sda_oe <= 1'b1;
              end
              ST_WDATA: begin
                wr_stb  <= 1'b1;
                wr_addr <= ptr;
                wr_data <= shreg;
                ptr     <= ptr + 1'b1;
                sda_oe  <= 1'b1;
              end
              default: begin
                sda_oe <= 1'b0;
                ptr    <= ptr + 1'b1;
              end
            endcase
          end else if (state == ST_RDATA) begin
            txsh   <= {txsh[DW-2:0], 1'b0};
            sda_oe <= ~txsh[DW-2];
          end
        end
      end
    end
  end

  assert_busy_silent_R9: assert property (@(posedge clk) disable iff (rst)
    $past(busy_i) |-> (!sda_oe && !wr_stb));
  assert_stop_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (stop_evt && !busy_i) |=> (state == ST_IDLE && !sda_oe));
  assert_restart_addr_R8: assert property (@(posedge clk) disable iff (rst)
    (start_evt && !stop_evt && !busy_i) |=> (state == ST_ADDR && bitcnt == '0));
  assert_drive_on_low_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(scl_s));
  assert_strobe_in_write_R5: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> ($past(state) == ST_WDATA));
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);
endmodule

// File: rtl/twi_regmem_slave.sv
module twi_regmem_slave #(
  parameter int         AW          = 7,
  parameter int         DW          = 8,
  parameter int         SW          = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] TYPE_CODE   = 4'b1010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [SW-1:0] strap_i,
  input  logic          wc_busy_i,
  output logic          sda_oe_o,
  output logic          wr_stb_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [AW-1:0] ptr;
  logic [DW-1:0] rd_data;

  twi_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  twi_proto_fsm #(.AW(AW), .DW(DW), .SW(SW), .TYPE_CODE(TYPE_CODE)) fsm_i (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .strap_i(strap_i), .busy_i(wc_busy_i), .rd_data(rd_data),
    .ptr(ptr), .sda_oe(sda_oe_o), .wr_stb(wr_stb_o),
    .wr_addr(wr_addr_o), .wr_data(wr_data_o)
  );

  twi_regfile #(.AW(AW), .DW(DW)) mem_i (
    .clk(clk), .we(wr_stb_o), .waddr(wr_addr_o), .wdata(wr_data_o),
    .raddr(ptr), .rdata(rd_data)
  );

  assert_reset_quiet_R11: assert property (@(posedge clk)
    $past(rst) |-> (!sda_oe_o && !wr_stb_o));
endmodule

// File: tb/twi_regmem_slave_tb_top.sv
`timescale 1ns/1ps
module twi_regmem_slave_tb_top;
  localparam int Q = 6;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] AW_BYTE = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] AR_BYTE = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic busy = 1'b0;
  logic sda_oe, wr_stb;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit quiet = 0;
  string quiet_tag = "R3";
  int model_mem [128];
  int ptr = 0;
  logic [14:0] exp_q [$];

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  twi_regmem_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .strap_i(STRAP),
    .wc_busy_i(busy), .sda_oe_o(sda_oe), .wr_stb_o(wr_stb),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  task automatic fail(input string req, input string what, input int act, input int exp);
    errors++;
    $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) fail(req, what, act, exp);
  endtask

  // per-clock comparison against the model's silence windows and write queue
  always @(negedge clk) begin
    if (!rst && quiet) begin
      checks++;
      if (sda_oe) fail(quiet_tag, "slave drove SDA while silent", 1, 0);
    end
    if (!rst && wr_stb) begin
      checks++;
      if (exp_q.size() == 0) fail("R5", "unexpected write strobe", {wr_addr, wr_data}, 0);
      else begin
        logic [14:0] e;
        e = exp_q.pop_front();
        if ({wr_addr, wr_data} != e) fail("R5", "write strobe addr/data", {wr_addr, wr_data}, e);
      end
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic set_quiet(input bit v, input string tag);
    @(posedge clk);
    quiet = v;
    quiet_tag = tag;
  endtask

  task automatic bus_bit(input logic mbit, output logic seen);
    wq(); sda_m = mbit;
    wq(); scl_m = 1'b1;
    wq(); wq(); seen = sda_line;
    scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wq(); sda_m = 1'b0;
    wq(); scl_m = 1'b1;
    wq(); sda_m = 1'b1;
    wq();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    logic seen;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], seen);
    bus_bit(1'b1, seen);
    check(req, "acknowledge of sent byte", !seen, exp_ack);
  endtask

  task automatic read_byte(input int exp, input bit give_ack, input string req);
    logic seen;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, seen);
      got[i] = seen;
    end
    bus_bit(!give_ack, seen);
    check(req, "read byte", got, exp);
  endtask

  task automatic write_at(input int a, input int n, input int d0, input int d1, input int d2);
    int d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    bus_start();
    send_byte(AW_BYTE, 1, "R2");
    send_byte(a[7:0], 1, "R4");
    ptr = a & 127;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({ptr[6:0], d[i][7:0]});
      model_mem[ptr] = d[i];
      send_byte(d[i][7:0], 1, "R4");
      ptr = (ptr + 1) % 128;
    end
    bus_stop();
  endtask

  task automatic read_n(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      read_byte(model_mem[ptr], i < n - 1, req);
      ptr = (ptr + 1) % 128;
    end
  endtask

  task automatic read_at(input int a, input int n, input string req);
    bus_start();
    send_byte(AW_BYTE, 1, "R2");
    send_byte(a[7:0], 1, "R4");
    ptr = a & 127;
    bus_start();
    send_byte(AR_BYTE, 1, "R8");
    read_n(n, req);
    bus_stop();
  endtask

  initial begin
    logic seen;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11", "sda_oe after reset", sda_oe, 0);
    check("R11", "wr_stb after reset", wr_stb, 0);
    wq();

    // R4/R5: page write, word-address bit 7 ignored
    write_at(8'h90, 3, 8'hA5, 8'h3C, 8'hF0);
    // R6/R8: repeated-start read of three bytes
    read_at(8'h10, 3, "R6");
    // R5/R6: wrap from 127 to 0 on write and on read
    write_at(126, 3, 8'h11, 8'h22, 8'h33);
    read_at(127, 2, "R6");

    // R3: wrong strap bits, nothing acknowledged or stored
    set_quiet(1, "R3");
    bus_start();
    send_byte({4'b1010, STRAP ^ 3'b001, 1'b0}, 0, "R3");
    send_byte(8'h10, 0, "R3");
    send_byte(8'h77, 0, "R3");
    bus_stop();
    // R3: wrong type code
    bus_start();
    send_byte({4'b1011, STRAP, 1'b1}, 0, "R3");
    bus_stop();
    set_quiet(0, "R3");
    read_at(8'h10, 1, "R3");

    // R9: busy controller silences even a matching address
    busy = 1'b1;
    set_quiet(1, "R9");
    bus_start();
    send_byte(AW_BYTE, 0, "R9");
    send_byte(8'h10, 0, "R9");
    send_byte(8'h99, 0, "R9");
    bus_stop();
    set_quiet(0, "R9");
    busy = 1'b0;
    wq();
    read_at(8'h10, 1, "R9");

    // R7: NACK ends driving; further clocks see no response
    bus_start();
    send_byte(AR_BYTE, 1, "R2");
    read_n(1, "R7");
    set_quiet(1, "R7");
    for (int i = 0; i < 9; i++) bus_bit(1'b1, seen);
    check("R7", "line after NACK", seen, 1);
    bus_stop();
    set_quiet(0, "R7");

    // R1/R8: stop right after the word address, then a current-address read
    write_at(8'h20, 1, 8'h5A, 0, 0);
    bus_start();
    send_byte(AW_BYTE, 1, "R1");
    send_byte(8'h20, 1, "R1");
    ptr = 8'h20;
    bus_stop();
    bus_start();
    send_byte(AR_BYTE, 1, "R1");
    read_n(1, "R8");
    bus_stop();

    wq();
    check("R5", "pending expected writes", exp_q.size(), 0);
    check("R1", "sda_oe idle at end", sda_oe, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule